// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel. Its transfer parameters come from a chain of descriptors held in memory. Software writes the address of the first descriptor into the channel and sets the run bit. The channel then reads the four words of that descriptor and copies data item by item from the source address to the target address. When the descriptor is finished it follows the next pointer. It stops when the next pointer carries the stop flag. A mode that skips fetching lets software program one transfer directly into the channel's registers.

On the memory side the channel uses one request/grant port for both reads and writes. Each granted access receives exactly one response, with data and an error flag. Flow control is optional. When it is selected, each burst waits for a peripheral request line. Status flags for descriptor start, descriptor end and bus error drive a level interrupt, and software clears them by writing ones.

Top module: `chain_dma_channel`

## Requirements
- R1: After reset the control/status word (register address 0) reads 0x0000_0008. Only the stopped flag (bit 3) is set, and irq is low.
- R2: A descriptor is four 32-bit words at the pointer with its low four bits cleared. The words are, in order: next pointer, source, target, command. The channel follows the chain until a next pointer with bit 0 set completes. It then clears run (bit 31) and sets stopped (bit 3). While stopped it issues no memory request.
- R3: Command bits 15:14 select the item width: 1 is 1 byte, 2 is 2 bytes, 3 or 0 is 4 bytes. Bits 12:0 give the length in bytes. The channel moves ceil(length/width) items, each read from the source and then written to the target, in address order. A length of 0 moves nothing.
- R4: Command bit 31 advances the source by the item width after each item, and bit 30 does the same for the target. When the bit is clear, that address stays fixed.
- R5: When command bit 29 or bit 28 is set, each burst waits for periph_req before its first item. A burst is set by bits 17:16: 2 is 16 bytes, 3 is 32 bytes, 1 or 0 is 8 bytes. With both bits clear, the channel never waits for periph_req.
- R6: Bit 1 is set when a descriptor whose command bit 22 is set is loaded. Bit 2 is set when a descriptor whose command bit 21 is set completes.
- R7: Writing 1 to bit 0, 1 or 2 of register 0 clears that flag. Writing 0 leaves it unchanged.
- R8: An error response during a fetch or a transfer sets bit 0, clears run and sets stopped. No write follows the error.
- R9: Clearing run while a transfer is active stops the channel at the next burst boundary or descriptor end. Stopped then reads 1.
- R10: If bit 30 of register 0 is set when run is set, the channel performs one transfer from the source, target and command registers (addresses 2, 3, 4). It fetches nothing and then stops.
- R11: irq is high when bit 2, 1 or 0 is set, or when both the stop-interrupt enable (bit 29) and stopped are set.
- R12: Bit 8 of register 0 shows periph_req as sampled on the previous clock.
- R13: Writes to registers 1 to 4 are ignored while stopped reads 0.
- R14: A memory request, together with its address and direction, stays stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control/status, 1 pointer, 2 source, 3 target, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr, one cycle late |
| irq | output | 1 | Level interrupt |
| periph_req | input | 1 | Peripheral request used by flow control |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response for an accepted access |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_err | input | 1 | Error flag of the response |

## Verification
Some behaviour is checked by assertions on every cycle: a request is held stable until granted, a stopped channel issues no requests, an error response halts the channel on the next clock, and a write of 1 clears the bus-error flag. The bench's scenarios show everything else. This covers the order and values of data writes against a behavioural model of descriptor chains, the effect of item width and the increment bits on addresses, waiting at burst boundaries under flow control, the register-driven mode, register writes being ignored while active, and the final state of the status flags after stops, halts and bus errors.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  localparam int unsigned WORD_W = 32;

  // command word bit positions
  localparam int CMD_INC_SRC   = 31;
  localparam int CMD_INC_TGT   = 30;
  localparam int CMD_FLOW_SRC  = 29;
  localparam int CMD_FLOW_TGT  = 28;
  localparam int CMD_IRQ_START = 22;
  localparam int CMD_IRQ_END   = 21;

  // control/status bit positions
  localparam int CTL_RUN     = 31;
  localparam int CTL_NOFETCH = 30;
  localparam int CTL_STOPIE  = 29;
  localparam int CTL_PEND    = 8;
  localparam int CTL_STOPPED = 3;
  localparam int CTL_ENDF    = 2;
  localparam int CTL_STARTF  = 1;
  localparam int CTL_BERR    = 0;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_PTR  = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_TGT  = 3'd3;
  localparam logic [2:0] RA_CMD  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FRSP, S_GATE, S_RREQ, S_RRSP, S_WREQ, S_WRSP, S_END
  } seq_state_t;

  function automatic logic [2:0] item_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [5:0] burst_bytes(input logic [1:0] code);
    case (code)
      2'd2:    return 6'd16;
      2'd3:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        ev_start,
  input  logic        ev_end,
  input  logic        ev_err,
  input  logic        halt,
  input  logic        stopped,
  input  logic        preq,
  output logic        run,
  output logic        nofetch,
  output logic [31:0] ctrl_word,
  output logic        irq
);

  logic stopie, pend_q, f_end, f_start, f_err;
  logic ctrl_wr;
  logic unused_bits;

  assign ctrl_wr     = wr_en && (wr_addr == RA_CTRL);
  assign unused_bits = ^{wr_data[28:3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      nofetch <= 1'b0;
      stopie  <= 1'b0;
      pend_q  <= 1'b0;
      f_end   <= 1'b0;
      f_start <= 1'b0;
      f_err   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pend_q <= preq;
      if (ctrl_wr) begin
        run     <= wr_data[CTL_RUN];
        nofetch <= wr_data[CTL_NOFETCH];
        stopie  <= wr_data[CTL_STOPIE];
      end
      if (halt) run <= 1'b0;
      f_end   <= (f_end   & ~(ctrl_wr & wr_data[CTL_ENDF]))   | ev_end;
      f_start <= (f_start & ~(ctrl_wr & wr_data[CTL_STARTF])) | ev_start;
      f_err   <= (f_err   & ~(ctrl_wr & wr_data[CTL_BERR]))   | ev_err;
      irq     <= f_end | f_start | f_err | (stopie & stopped);
    end
  end

  assign ctrl_word = {run, nofetch, stopie, 20'd0, pend_q, 4'd0,
                      stopped, f_end, f_start, f_err};

endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        nofetch,
  input  logic        preq,
  input  logic        sw_wr,
  input  logic [2:0]  sw_addr,
  input  logic [31:0] sw_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        ev_start,
  output logic        ev_end,
  output logic        ev_err,
  output logic        halt,
  output logic        stopped,
  output logic [31:0] ptr_q,
  output logic [31:0] src_q,
  output logic [31:0] tgt_q,
  output logic [31:0] cmd_q
);

  localparam int BW = 6;

  seq_state_t       state;
  logic [1:0]       widx;
  logic [31:0]      fetch_base;
  logic             mode_nf;
  logic [LEN_W-1:0] left_q;
  logic [BW-1:0]    burst_left;
  logic [31:0]      data_q;

  logic [2:0]       ib;
  logic             last_item, flow, rsp_ok, rsp_bad, chain_stop;
  logic [LEN_W-1:0] fetched_len;

  assign ib          = item_bytes(cmd_q[15:14]);
  assign last_item   = left_q <= LEN_W'(ib);
  assign flow        = cmd_q[CMD_FLOW_SRC] | cmd_q[CMD_FLOW_TGT];
  assign rsp_ok      = mem_rvalid && !mem_err;
  assign rsp_bad     = mem_rvalid && mem_err &&
                       (state == S_FRSP || state == S_RRSP || state == S_WRSP);
  assign chain_stop  = mode_nf || ptr_q[0];
  assign fetched_len = mem_rdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      widx       <= 2'd0;
      fetch_base <= '0;
      mode_nf    <= 1'b0;
      left_q     <= '0;
      burst_left <= '0;
      data_q     <= '0;
      ptr_q      <= '0;
      src_q      <= '0;
      tgt_q      <= '0;
      cmd_q      <= '0;
    end else begin
      if (state == S_IDLE && sw_wr) begin
        case (sw_addr)
          RA_PTR:  ptr_q <= sw_data;
          RA_SRC:  src_q <= sw_data;
          RA_TGT:  tgt_q <= sw_data;
          RA_CMD:  cmd_q <= sw_data;
          default: ;
        endcase
      end
      unique case (state)
        S_IDLE: if (run) begin
          mode_nf <= nofetch;
          if (nofetch) begin
            left_q <= cmd_q[LEN_W-1:0];
            state  <= (cmd_q[LEN_W-1:0] == '0) ? S_END : S_GATE;
          end else begin
            fetch_base <= {ptr_q[31:4], 4'b0000};
            widx       <= 2'd0;
            state      <= S_FREQ;
          end
        end
        S_FREQ: if (mem_gnt) state <= S_FRSP;
        S_FRSP: if (mem_rvalid) begin
          if (mem_err) state <= S_IDLE;
          else begin
            case (widx)
              2'd0: ptr_q <= mem_rdata;
              2'd1: src_q <= mem_rdata;
              2'd2: tgt_q <= mem_rdata;
              default: begin
                cmd_q  <= mem_rdata;
                left_q <= fetched_len;
              end
            endcase
            if (widx == 2'd3)
              state <= (fetched_len == '0) ? S_END : S_GATE;
            else begin
              widx  <= widx + 2'd1;
              state <= S_FREQ;
            end
          end
        end
        S_GATE: begin
          if (!run) state <= S_IDLE;
          else if (!flow || preq) begin
            burst_left <= burst_bytes(cmd_q[17:16]);
            state      <= S_RREQ;
          end
        end
        S_RREQ: if (mem_gnt) state <= S_RRSP;
        S_RRSP: if (mem_rvalid) begin
          if (mem_err) state <= S_IDLE;
          else begin
            data_q <= mem_rdata;
            state  <= S_WREQ;
          end
        end
        S_WREQ: if (mem_gnt) state <= S_WRSP;
        S_WRSP: if (mem_rvalid) begin
          if (mem_err) state <= S_IDLE;
          else begin
            if (cmd_q[CMD_INC_SRC]) src_q <= src_q + 32'(ib);
            if (cmd_q[CMD_INC_TGT]) tgt_q <= tgt_q + 32'(ib);
            left_q     <= last_item ? '0 : left_q - LEN_W'(ib);
            burst_left <= burst_left - BW'(ib);
            if (last_item)                      state <= S_END;
            else if (burst_left <= BW'(ib))     state <= S_GATE;
            else                                state <= S_RREQ;
          end
        end
        S_END: begin
          if (chain_stop || !run) state <= S_IDLE;
          else begin
            fetch_base <= {ptr_q[31:4], 4'b0000};
            widx       <= 2'd0;
            state      <= S_FREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_FREQ) || (state == S_RREQ) || (state == S_WREQ);
  assign mem_we    = (state == S_WREQ);
  assign mem_wdata = data_q;

  always_comb begin
    mem_addr = '0;
    mem_size = size_code(cmd_q[15:14]);
    case (state)
      S_FREQ: begin
        mem_addr = fetch_base + {28'd0, widx, 2'b00};
        mem_size = 2'd2;
      end
      S_RREQ:  mem_addr = src_q;
      S_WREQ:  mem_addr = tgt_q;
      default: ;
    endcase
  end

  assign ev_err   = rsp_bad;
  assign ev_start = (state == S_FRSP && rsp_ok && widx == 2'd3 && mem_rdata[CMD_IRQ_START]) ||
                    (state == S_IDLE && run && nofetch && cmd_q[CMD_IRQ_START]);
  assign ev_end   = (state == S_END) && cmd_q[CMD_IRQ_END];
  assign halt     = rsp_bad || (state == S_END && chain_stop);
  assign stopped  = (state == S_IDLE);

endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        periph_req,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);

  logic        run_w, nofetch_w, stopped_w, halt_w;
  logic        ev_start_w, ev_end_w, ev_err_w;
  logic [31:0] ctrl_word, ptr_w, src_w, tgt_w, cmd_w;

  chain_dma_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .ev_start (ev_start_w),
    .ev_end   (ev_end_w),
    .ev_err   (ev_err_w),
    .halt     (halt_w),
    .stopped  (stopped_w),
    .preq     (periph_req),
    .run      (run_w),
    .nofetch  (nofetch_w),
    .ctrl_word(ctrl_word),
    .irq      (irq)
  );

  chain_dma_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .nofetch   (nofetch_w),
    .preq      (periph_req),
    .sw_wr     (reg_wr),
    .sw_addr   (reg_addr),
    .sw_data   (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .ev_start  (ev_start_w),
    .ev_end    (ev_end_w),
    .ev_err    (ev_err_w),
    .halt      (halt_w),
    .stopped   (stopped_w),
    .ptr_q     (ptr_w),
    .src_q     (src_w),
    .tgt_q     (tgt_w),
    .cmd_q     (cmd_w)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= ctrl_word;
        RA_PTR:  reg_rdata <= ptr_w;
        RA_SRC:  reg_rdata <= src_w;
        RA_TGT:  reg_rdata <= tgt_w;
        RA_CMD:  reg_rdata <= cmd_w;
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        mem_err,
  input logic        stopped,
  input logic        run,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        err_flag
);

  // R14: an ungranted request keeps its address and direction
  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2: a stopped channel stays off the memory port
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !mem_req);

  // R8: an error response halts the channel on the next clock
  p_err_halts_r8: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid && mem_err |=> !run && stopped);

  // R7: writing 1 to the bus-error bit clears it
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !(mem_rvalid && mem_err) |=> !err_flag);

endmodule

bind chain_dma_channel chain_dma_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_rvalid(mem_rvalid),
  .mem_err   (mem_err),
  .stopped   (stopped_w),
  .run       (run_w),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .err_flag  (ctrl_word[0])
);

// File: tb/sim_chain_dma_channel.sv
module sim_chain_dma_channel;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        periph_req = 1'b0;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        mem_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_dma_channel u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .periph_req(periph_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  function automatic void chk(input bit ok, input string req,
                              input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:MEM_BYTES-1];
  logic [3:0]  stall_cnt;
  logic        gnt_en;
  int          wr_seen = 0;
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  int          exp_nb[$];
  int          m_nb;
  logic [31:0] m_d, m_mask, e_a, e_d;

  assign mem_gnt = mem_req & gnt_en;

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_err    <= 1'b0;
      mem_rdata  <= '0;
      stall_cnt  <= '0;
      gnt_en     <= 1'b1;
    end else begin
      stall_cnt  <= stall_cnt + 4'd1;
      gnt_en     <= (stall_cnt[1:0] != 2'd3);
      mem_rvalid <= mem_req && mem_gnt;
      mem_err    <= 1'b0;
      if (mem_req && mem_gnt) begin
        m_nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
        m_mask = (m_nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*m_nb)) - 32'd1);
        if (mem_addr >= MEM_BYTES) mem_err <= 1'b1;
        else if (mem_we) begin
          wr_seen++;
          if (exp_addr.size() == 0) chk(0, "R3 unexpected write", mem_addr, 32'hx);
          else begin
            e_a = exp_addr.pop_front(); e_d = exp_data.pop_front(); void'(exp_nb.pop_front());
            chk(mem_addr == e_a, "R4 write address", mem_addr, e_a);
            chk((mem_wdata & m_mask) == (e_d & m_mask), "R3 write data", mem_wdata & m_mask, e_d & m_mask);
          end
          for (int k = 0; k < m_nb; k++) mem[(mem_addr + k) % MEM_BYTES] = mem_wdata[8*k +: 8];
        end else begin
          m_d = '0;
          for (int k = 0; k < m_nb; k++) m_d[8*k +: 8] = mem[(mem_addr + k) % MEM_BYTES];
          mem_rdata <= m_d;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  task automatic put_desc(input int a, input logic [31:0] nx, s, t, c);
    put32(a, nx); put32(a + 4, s); put32(a + 8, t); put32(a + 12, c);
  endtask

  // behavioural model: expected writes of one descriptor
  task automatic model_xfer(input logic [31:0] s, t, c);
    int w, len, n;
    logic [31:0] d, as, at;
    w = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
    len = int'(c[12:0]);
    n = (len + w - 1) / w;
    for (int i = 0; i < n; i++) begin
      as = s + (c[31] ? 32'(i*w) : 32'd0);
      at = t + (c[30] ? 32'(i*w) : 32'd0);
      d = '0;
      for (int k = 0; k < w; k++) d[8*k +: 8] = mem[(as + k) % MEM_BYTES];
      exp_addr.push_back(at); exp_data.push_back(d); exp_nb.push_back(w);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_stop(output logic [31:0] v);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      reg_read(3'd0, v);
      if (v[3]) return;
    end
    chk(0, "R2 channel never stopped", v, 32'h8);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  localparam logic [31:0] INC2 = 32'hC000_0000;
  localparam logic [31:0] W1 = 32'd1 << 14, W2 = 32'd2 << 14, W4 = 32'd3 << 14;
  localparam logic [31:0] B8 = 32'd1 << 16, B32 = 32'd3 << 16;
  localparam logic [31:0] IST = 32'd1 << 22, IEN = 32'd1 << 21, FLOWS = 32'd1 << 29;

  initial begin
    logic [31:0] v;
    int base_w;
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_read(3'd0, v);
    chk(v == 32'h0000_0008, "R1 reset status", v, 32'h8);
    chk(irq == 1'b0, "R1 reset irq", {31'd0, irq}, 32'd0);

    // R2/R3/R4/R6: two-descriptor chain, misaligned next pointer low bits
    put_desc(32'h100, 32'h12C, 32'h400, 32'h800, INC2 | W4 | B32 | IST | 32'd16);
    put_desc(32'h120, 32'h001, 32'h410, 32'h900, INC2 | W2 | IEN | 32'd5);
    model_xfer(32'h400, 32'h800, INC2 | W4 | 32'd16);
    model_xfer(32'h410, 32'h900, INC2 | W2 | 32'd5);
    reg_write(3'd1, 32'h100);
    reg_write(3'd0, 32'h8000_0000);
    wait_stop(v);
    chk(v == 32'h0000_000E, "R2 R6 status after chain", v, 32'hE);
    chk(exp_addr.size() == 0, "R3 all chain items written", exp_addr.size(), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq on flags", {31'd0, irq}, 32'd1);

    // R7 write-one-to-clear
    reg_write(3'd0, 32'h4);
    reg_read(3'd0, v);
    chk(v == 32'h0A, "R7 clear end only", v, 32'h0A);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, v);
    chk(v == 32'h0A, "R7 zero write keeps flags", v, 32'h0A);
    reg_write(3'd0, 32'h2);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11 irq low when clear", {31'd0, irq}, 32'd0);

    // R11 stop interrupt enable
    reg_write(3'd0, 32'h2000_0000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R11 stop irq", {31'd0, irq}, 32'd1);
    reg_write(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11 stop irq off", {31'd0, irq}, 32'd0);

    // R4 fixed target, R3 byte width
    put_desc(32'h140, 32'h001, 32'h420, 32'hA00, 32'h8000_0000 | W1 | 32'd3);
    model_xfer(32'h420, 32'hA00, 32'h8000_0000 | W1 | 32'd3);
    reg_write(3'd1, 32'h140);
    reg_write(3'd0, 32'h8000_0000);
    wait_stop(v);
    chk(v == 32'h08, "R4 fixed target status", v, 32'h08);
    chk(exp_addr.size() == 0, "R4 fixed target items", exp_addr.size(), 0);

    // R5 flow control, R12 pending bit, R13 writes ignored while busy
    put_desc(32'h160, 32'h001, 32'h440, 32'hB00, INC2 | FLOWS | B8 | W4 | 32'd16);
    model_xfer(32'h440, 32'hB00, INC2 | W4 | 32'd16);
    base_w = wr_seen;
    reg_write(3'd1, 32'h160);
    reg_write(3'd0, 32'h8000_0000);
    repeat (40) @(negedge clk);
    chk(wr_seen == base_w, "R5 waits for request", wr_seen - base_w, 0);
    reg_read(3'd0, v);
    chk(v == 32'h8000_0000, "R5 R12 active, no pending", v, 32'h8000_0000);
    reg_write(3'd2, 32'h0000_0FF0);
    reg_read(3'd2, v);
    chk(v == 32'h440, "R13 source write ignored while active", v, 32'h440);
    periph_req = 1'b1;
    for (int i = 0; i < 500 && wr_seen < base_w + 2; i++) @(negedge clk);
    periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_seen == base_w + 2, "R5 stops at burst boundary", wr_seen - base_w, 2);
    periph_req = 1'b1;
    @(negedge clk);
    reg_read(3'd0, v);
    chk(v[8] == 1'b1, "R12 pending bit", {31'd0, v[8]}, 32'd1);
    wait_stop(v);
    chk(v == 32'h108, "R5 flow transfer done", v, 32'h108);
    chk(exp_addr.size() == 0, "R5 flow items", exp_addr.size(), 0);
    periph_req = 1'b0;

    // R9 software halt
    put_desc(32'h180, 32'h001, 32'h450, 32'hB80, INC2 | FLOWS | W4 | 32'd8);
    base_w = wr_seen;
    reg_write(3'd1, 32'h180);
    reg_write(3'd0, 32'h8000_0000);
    repeat (20) @(negedge clk);
    reg_write(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    reg_read(3'd0, v);
    chk(v == 32'h08, "R9 halted by run clear", v, 32'h08);
    chk(wr_seen == base_w, "R9 no writes", wr_seen - base_w, 0);

    // R8 bus error during transfer
    put_desc(32'h1A0, 32'h001, 32'h2000, 32'hC00, INC2 | W4 | 32'd8);
    reg_write(3'd1, 32'h1A0);
    reg_write(3'd0, 32'h8000_0000);
    wait_stop(v);
    chk(v == 32'h09, "R8 data bus error", v, 32'h09);
    chk(wr_seen == base_w, "R8 no write after error", wr_seen - base_w, 0);
    reg_write(3'd0, 32'h1);
    reg_read(3'd0, v);
    chk(v == 32'h08, "R7 bus error cleared", v, 32'h08);

    // R8 bus error during fetch
    reg_write(3'd1, 32'h3000);
    reg_write(3'd0, 32'h8000_0000);
    wait_stop(v);
    chk(v == 32'h09, "R8 fetch bus error", v, 32'h09);
    reg_write(3'd0, 32'h1);

    // R10 register-driven single transfer
    reg_write(3'd2, 32'h460);
    reg_write(3'd3, 32'hD00);
    reg_write(3'd4, INC2 | W4 | IEN | 32'd8);
    model_xfer(32'h460, 32'hD00, INC2 | W4 | 32'd8);
    reg_write(3'd0, 32'hC000_0000);
    wait_stop(v);
    chk(v == 32'h4000_000C, "R10 no-fetch transfer", v, 32'h4000_000C);
    chk(exp_addr.size() == 0, "R10 items", exp_addr.size(), 0);
    reg_read(3'd1, v);
    chk(v == 32'h3000, "R10 pointer untouched", v, 32'h3000);
    reg_write(3'd0, 32'h4);

    // R3 zero length
    put_desc(32'h1C0, 32'h001, 32'h470, 32'hE00, INC2 | W4 | IEN);
    base_w = wr_seen;
    reg_write(3'd1, 32'h1C0);
    reg_write(3'd0, 32'h8000_0000);
    wait_stop(v);
    chk(v == 32'h0C, "R3 zero length ends", v, 32'h0C);
    chk(wr_seen == base_w, "R3 zero length no writes", wr_seen - base_w, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule